// File: doc/BRIEF.md
# Cable Test Pattern Generator

This block drives a parallel bus of test signals so that every conductor of a multi-line data cable carries its own recognisable pattern. A receiver that runs the same generator can then spot broken, swapped or crossed lines. The source of all lines is one pseudo-random sequence generator with a full period of 32767 clocks. Sixteen primary lines are taken at different delays of that sequence. Sixteen more lines are the complements of the primary lines. A parameterised number of extra lines are primary lines mixed with a signal that toggles on every clock, which is half the clock rate.

A once-per-second pulse reloads the generator synchronously, so sender and receiver restart the pattern together. A test-enable input is registered into a two-state mode machine. In state USER the user data bus passes straight to the output. In state TEST the generated pattern replaces the user data. The transition ENGAGE goes from USER to TEST when the registered enable is high. The transition RELEASE goes from TEST back to USER when it is low. The generator keeps running in both states.

Top module: `cable_pattern_gen`

## Requirements
- R1: While reset is asserted, the mode is USER and `line_out` equals `user_data`. Reset loads the sequence register with the seed `SEED` (default 15'h1ACE), clears the delay chain and clears the toggle.
- R2: The sequence register shifts left by one each clock, and the feedback bit `s[14] ^ s[13]` enters bit 0. Its serial output is `s[14]`. The register never holds zero, and lines 0..15 repeat exactly after 32767 clocks with no reload.
- R3: Line i (0..15) equals the serial output delayed by i+1 clocks. The delay chain shifts the serial bit into line 0, and line i moves on to line i+1.
- R4: Line 16+i equals the inverse of line i, for i in 0..15.
- R5: Extra line 32+k equals line k XOR the toggle, for k in 0..EXTRA-1. The toggle inverts on every clock and is 0 after reset or reload.
- R6: A clock edge with `pps` high reloads the seed, clears the delay chain and clears the toggle, in the same way as reset. While `pps` stays high, the state stays there.
- R7: `test_en` is sampled at each clock edge. From the next cycle the mode is TEST (ENGAGE) and `line_out` shows the pattern, or the mode is USER (RELEASE) and `line_out` equals `user_data` unchanged in the same cycle.
- R8: Once the chain has filled after a reload, every pair of output lines differs at least once over any 64 consecutive clocks.
- R9: The generator advances on every clock whatever the mode, so a stretch in USER mode does not shift the pattern phase seen after returning to TEST.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pps | input | 1 | Once-per-second synchronous reload pulse |
| test_en | input | 1 | Selects the test pattern in place of user data (registered) |
| user_data | input | 2*PRIMARY+EXTRA | Normal user data bus |
| line_out | output | 2*PRIMARY+EXTRA | Bus to the cable line drivers |

## Verification
The bench builds the block with PRIMARY=16 and EXTRA=3, which gives a 35-line bus. The odd extra count leaves the default of two, so the generate loop for the mixed lines is exercised beyond its default width. Because the sequence register stays at its 15-bit default, a full 32767-clock period fits in the run. That makes it possible to check exact repetition of the primary and complement lines. The toggle has period 2 and the sequence period is odd, so the extra lines come back inverted after that same span. A USER-mode stretch placed inside the period run shows that the generator keeps advancing in that state.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

    typedef enum logic {
        MODE_USER = 1'b0,
        MODE_TEST = 1'b1
    } mode_e;

endpackage

// File: rtl/cpg_lfsr.sv
module cpg_lfsr #(
    parameter int              W      = 15,
    parameter int              TAP_HI = 14,
    parameter int              TAP_LO = 13,
    parameter logic [W-1:0]    SEED   = 15'h1ACE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pps,
    output logic serial_bit
);

    logic [W-1:0] state_q;
    logic         feedback;

    assign feedback   = state_q[TAP_HI] ^ state_q[TAP_LO];
    assign serial_bit = state_q[W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (pps) begin
            state_q <= SEED;
        end else begin
            state_q <= {state_q[W-2:0], feedback};
        end
    end

    // R2: a maximal-length register never reaches the all-zero lock state
    a_r2_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

    // R6: a reload pulse restores the seed on the following cycle
    a_r6_seed_reload: assert property (@(posedge clk) disable iff (!rst_n)
        pps |=> (state_q == SEED));

endmodule

// File: rtl/cpg_delay_chain.sv
module cpg_delay_chain #(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pps,
    input  logic             din,
    output logic [DEPTH-1:0] taps
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taps <= '0;
        end else if (pps) begin
            taps <= '0;
        end else begin
            taps <= {taps[DEPTH-2:0], din};
        end
    end

    // R3: the first tap holds the serial bit from the previous cycle
    a_r3_first_tap: assert property (@(posedge clk) disable iff (!rst_n)
        !pps |=> (taps[0] == $past(din)));

    // R6: a reload pulse empties the chain
    a_r6_chain_clear: assert property (@(posedge clk) disable iff (!rst_n)
        pps |=> (taps == '0));

endmodule

// File: rtl/cpg_line_map.sv
module cpg_line_map #(
    parameter int PRIMARY = 16,
    parameter int EXTRA   = 2,
    localparam int LINES  = 2 * PRIMARY + EXTRA
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pps,
    input  logic [PRIMARY-1:0] taps,
    output logic [LINES-1:0]   pattern
);

    logic toggle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            toggle_q <= 1'b0;
        end else if (pps) begin
            toggle_q <= 1'b0;
        end else begin
            toggle_q <= ~toggle_q;
        end
    end

    assign pattern[PRIMARY-1:0]         = taps;
    assign pattern[2*PRIMARY-1:PRIMARY] = ~taps;

    for (genvar k = 0; k < EXTRA; k++) begin : g_mixed
        assign pattern[2*PRIMARY+k] = taps[k] ^ toggle_q;
    end

    // R5: the half-rate toggle inverts on every clock without a reload
    a_r5_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
        !pps |=> (toggle_q != $past(toggle_q)));

    // R6: a reload pulse clears the toggle
    a_r6_toggle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        pps |=> (toggle_q == 1'b0));

endmodule

// File: rtl/cable_pattern_gen.sv
module cable_pattern_gen #(
    parameter int                  LFSR_W  = 15,
    parameter int                  TAP_HI  = 14,
    parameter int                  TAP_LO  = 13,
    parameter logic [LFSR_W-1:0]   SEED    = 15'h1ACE,
    parameter int                  PRIMARY = 16,
    parameter int                  EXTRA   = 2,
    localparam int                 LINES   = 2 * PRIMARY + EXTRA
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pps,
    input  logic             test_en,
    input  logic [LINES-1:0] user_data,
    output logic [LINES-1:0] line_out
);

    import cpg_pkg::*;

    logic               serial_bit;
    logic [PRIMARY-1:0] taps;
    logic [LINES-1:0]   pattern;
    mode_e              mode_q;
    mode_e              mode_d;

    cpg_lfsr #(
        .W      (LFSR_W),
        .TAP_HI (TAP_HI),
        .TAP_LO (TAP_LO),
        .SEED   (SEED)
    ) u_lfsr (
        .clk        (clk),
        .rst_n      (rst_n),
        .pps        (pps),
        .serial_bit (serial_bit)
    );

    cpg_delay_chain #(
        .DEPTH (PRIMARY)
    ) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .pps   (pps),
        .din   (serial_bit),
        .taps  (taps)
    );

    cpg_line_map #(
        .PRIMARY (PRIMARY),
        .EXTRA   (EXTRA)
    ) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .pps     (pps),
        .taps    (taps),
        .pattern (pattern)
    );

    // Mode transitions: ENGAGE (USER -> TEST), RELEASE (TEST -> USER)
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_USER: if (test_en)  mode_d = MODE_TEST;
            MODE_TEST: if (!test_en) mode_d = MODE_USER;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_USER;
        end else begin
            mode_q <= mode_d;
        end
    end

    always_comb begin
        line_out = user_data;
        unique case (mode_q)
            MODE_USER: line_out = user_data;
            MODE_TEST: line_out = pattern;
        endcase
    end

    // R7: a sampled enable puts the block in TEST mode on the next cycle
    a_r7_engage: assert property (@(posedge clk) disable iff (!rst_n)
        test_en |=> (mode_q == MODE_TEST));

    // R7: a sampled low enable passes user data through on the next cycle
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> (line_out == user_data));

endmodule

// File: tb/sim_cable_pattern_gen.sv
module sim_cable_pattern_gen;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int          P    = 16;
    localparam int          X    = 3;
    localparam int          N    = 2 * P + X;
    localparam logic [14:0] SEED = 15'h1ACE;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pps = 1'b0;
    logic         test_en = 1'b0;
    logic [N-1:0] user_data = '0;
    logic [N-1:0] line_out;

    logic [14:0]  m_lfsr;
    logic [P-1:0] m_chain;
    logic         m_tgl;
    logic         m_test;

    int vectors = 0;
    int miscompares = 0;

    cable_pattern_gen #(
        .PRIMARY (P),
        .EXTRA   (X)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .pps       (pps),
        .test_en   (test_en),
        .user_data (user_data),
        .line_out  (line_out)
    );

    always #5 clk = ~clk;

    function automatic logic [N-1:0] exp_pattern(input logic [P-1:0] ch, input logic t);
        logic [N-1:0] r;
        r[P-1:0]     = ch;
        r[2*P-1:P]   = ~ch;
        for (int k = 0; k < X; k++) r[2*P+k] = ch[k] ^ t;
        return r;
    endfunction

    // Reference model of R2, R3, R5, R6, R7, advanced at each edge out of reset
    always @(posedge clk) begin
        if (rst_n) begin
            if (pps) begin
                m_lfsr  = SEED;
                m_chain = '0;
                m_tgl   = 1'b0;
            end else begin
                m_chain = {m_chain[P-2:0], m_lfsr[14]};
                m_lfsr  = {m_lfsr[13:0], m_lfsr[14] ^ m_lfsr[13]};
                m_tgl   = ~m_tgl;
            end
            m_test = test_en;
        end
    end

    task automatic check_out(input string tag);
        logic [N-1:0] e;
        string        t;
        e = m_test ? exp_pattern(m_chain, m_tgl) : user_data;
        vectors++;
        if (line_out !== e) begin
            miscompares++;
            if (tag != "")                          t = tag;
            else if (!m_test)                       t = "R7";
            else if (line_out[P-1:0] !== e[P-1:0])  t = "R3";
            else if (line_out[2*P-1:P] !== e[2*P-1:P]) t = "R4";
            else                                    t = "R5";
            $display("FAIL %s: line_out=%h expected=%h", t, line_out, e);
        end
    endtask

    task automatic step(input logic p, input logic en, input string tag);
        @(negedge clk);
        pps       = p;
        test_en   = en;
        user_data = N'({$urandom(), $urandom()});
        #1;
        check_out(tag);
    endtask

    initial begin
        #1_500_000;
        miscompares++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [N-1:0] win [64];
        logic [N-1:0] w0;
        logic         ok;
        void'($urandom(32'd1234));
        m_lfsr  = SEED;
        m_chain = '0;
        m_tgl   = 1'b0;
        m_test  = 1'b0;

        // R1: in reset the enable has no effect, user data passes through
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, "R1");
        @(negedge clk);
        rst_n = 1'b1;

        // R1/R3/R4/R5: pattern from the reset state, chain filling
        for (int i = 0; i < 24; i++) step(1'b0, 1'b1, "");

        // R6: reload pulse, then R8 distinctness window after the chain fills
        step(1'b1, 1'b1, "");
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1, "");
        for (int i = 0; i < 64; i++) begin
            step(1'b0, 1'b1, "");
            win[i] = line_out;
        end
        ok = 1'b1;
        for (int a = 0; a < N; a++)
            for (int b = a + 1; b < N; b++) begin
                logic diff;
                diff = 1'b0;
                for (int t = 0; t < 64; t++) if (win[t][a] != win[t][b]) diff = 1'b1;
                if (!diff) begin
                    ok = 1'b0;
                    $display("FAIL R8: lines %0d and %0d equal over window, actual=same expected=differ", a, b);
                end
            end
        vectors++;
        if (!ok) miscompares++;

        // R2/R9: exact repeat of lines 0..31 after 32767 clocks, USER stretch inside
        w0 = line_out;
        for (int i = 0; i < 32767; i++) begin
            if (i >= 1000 && i < 1150) step(1'b0, 1'b0, "");
            else                       step(1'b0, 1'b1, "");
        end
        vectors++;
        if (line_out[2*P-1:0] !== w0[2*P-1:0]) begin
            miscompares++;
            $display("FAIL R2/R9: period repeat actual=%h expected=%h",
                     line_out[2*P-1:0], w0[2*P-1:0]);
        end
        // R5: toggle phase flips over the odd period
        vectors++;
        if (line_out[N-1:2*P] !== (w0[N-1:2*P] ^ {X{1'b1}})) begin
            miscompares++;
            $display("FAIL R5: extra lines actual=%h expected=%h",
                     line_out[N-1:2*P], w0[N-1:2*P] ^ {X{1'b1}});
        end

        // R6: reload held two cycles, then reload while in USER mode
        step(1'b1, 1'b1, "R6");
        step(1'b1, 1'b1, "R6");
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1, "R6");
        step(1'b1, 1'b0, "R6");
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, "R9");
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1, "R9");

        // R7: single-cycle enable pulse
        step(1'b0, 1'b0, "R7");
        step(1'b0, 1'b1, "R7");
        step(1'b0, 1'b0, "R7");
        step(1'b0, 1'b0, "R7");

        // Random mix of reload pulses, mode changes and user data
        begin
            logic en;
            en = 1'b1;
            for (int i = 0; i < 4000; i++) begin
                if ($urandom_range(49) == 0) en = ~en;
                step(($urandom_range(199) == 0), en, "");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule